// File: doc/BRIEF.md
# Gray-Scale PWM Segment Generator

This block turns stored pixel codes into on/off enables for the segment drivers of a multiplexed LCD. It works within one common period at a time. A period is cut into equal sections. Each segment stays active from the first section until its pixel's programmed width runs out. The longer a segment is driven, the darker it appears, so four gray shades come from one binary driver.

Pixels arrive packed two per 4-bit word. Each 2-bit code picks one of four gray levels. The host programs every level with a 5-bit pulse width using a 15-bit configuration word. A frame-mode input sets the number of sections per period, 24 (long) or 13 (short), and this also sets the largest width that can be used. Level widths, pixel data and the frame mode are all captured only at the start of a common period. A pulse in progress is therefore never cut short or stretched. A section counter moves through the period on a state machine with three states:

- S_IDLE: no period has started since reset.
- S_COUNT: the counter is advancing.
- S_SAT: the counter has reached the last section and waits there.

The transitions are:

- S_IDLE goes to S_COUNT on a period start.
- S_COUNT goes to S_SAT on the tick that reaches the last section.
- S_COUNT goes back to S_COUNT (restart) on a period start.
- S_SAT goes to S_COUNT on a period start.

Top module: `gs_pwm_seg`

## Requirements
- R1: During reset and until the first `period_start` after it, every `seg_on` bit is 0. At reset all level widths are 0 and the long frame mode is active, so a period started without programming leaves every segment inactive.
- R2: Word w of `pix_data` occupies bits [4w+3:4w]. Bits [4w+3:4w+2] drive segment 2w and bits [4w+1:4w] drive segment 2w+1. Code 11 selects level 1, 10 selects level 2, 01 selects level 3 and 00 selects level 4.
- R3: A configuration word is accepted when `cfg_valid` is 1, bits [14:12] equal 100 and bits [11:9] are 001 to 100 (naming levels 1 to 4). Bits [8:4] then become that level's width and bits [3:0] are ignored. Any other identifier or level field changes nothing.
- R4: Within a period, a segment is active exactly while the section index is below the clamped width of its pixel's level. Its pulse therefore lasts min(width, limit) sections starting at section 0, and a larger width never gives a shorter pulse.
- R5: With `mode_short` = 0 captured, the period has sections 0 to 23 and any width above 23 acts as 23.
- R6: With `mode_short` = 1 captured, the period has sections 0 to 12 and any width above 12 acts as 12.
- R7: `period_start` sets the section index to 0. Each `sect_tick` after that adds one. The index stops at the last section until the next start. When `period_start` and `sect_tick` arrive in the same cycle, the start wins.
- R8: Level widths, pixel data and frame mode affect the outputs only from the next `period_start`. A configuration word accepted in the same cycle as a start waits for the start after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start | input | 1 | One-cycle pulse opening a common period |
| sect_tick | input | 1 | One-cycle pulse advancing to the next section |
| mode_short | input | 1 | Frame mode, 0 = 24 sections, 1 = 13 sections |
| cfg_valid | input | 1 | Configuration word strobe |
| cfg_word | input | 15 | Identifier [14:12], level [11:9], width [8:4], unused [3:0] |
| pix_data | input | 4*NUM_WORDS | Packed pixel words, two 2-bit codes each |
| seg_on | output | 2*NUM_WORDS | Active flag per segment |

## Verification
Every internal register shows up at `seg_on` within one period. The effects of the main kinds of fault are as follows:

- A wrong section count, whether it skips, wraps or fails to saturate, changes the number of cycles a segment stays high. A wrap after saturation makes a dark segment light up again late in the period.
- A wrong capture of levels, pixels or mode shows up on the first observation after the `period_start` that should have applied it. A capture taken too early shows up one cycle after the configuration write, while the old period is still running.
- A swapped pixel half or an inverted code-to-level map is seen as soon as levels with distinct widths are in use.

Directed cases measure exact pulse lengths in both modes, and a seeded random phase compares every cycle against a bench model.

// File: rtl/gs_pkg.sv
package gs_pkg;
    localparam int PWM_W   = 5;
    localparam int NUM_LVL = 4;
    localparam int CFG_W   = 15;
    localparam logic [2:0] CFG_ID_LEVEL = 3'b100;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_COUNT = 2'd1,
        S_SAT   = 2'd2
    } sect_state_t;
endpackage

// File: rtl/gs_level_bank.sv
module gs_level_bank
    import gs_pkg::*;
#(
    parameter int NLVL = NUM_LVL,
    parameter int WW   = PWM_W,
    parameter int CW   = CFG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_valid,
    input  logic [CW-1:0]      cfg_word,
    input  logic               load,
    output logic [NLVL*WW-1:0] lvl_act
);
    logic [2:0]    cfg_id;
    logic [2:0]    cfg_sel;
    logic [WW-1:0] cfg_val;
    logic          cfg_hit;

    assign cfg_id  = cfg_word[CW-1 -: 3];
    assign cfg_sel = cfg_word[CW-4 -: 3];
    assign cfg_val = cfg_word[CW-7 -: WW];
    assign cfg_hit = cfg_valid && (cfg_id == CFG_ID_LEVEL) &&
                     (cfg_sel != 3'd0) && (cfg_sel <= 3'(NLVL));

    for (genvar k = 0; k < NLVL; k++) begin : g_lvl
        logic [WW-1:0] pend_q;
        logic [WW-1:0] act_q;

        // host-side copy, written at any time
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= '0;
            end else if (cfg_hit && (cfg_sel == 3'(k + 1))) begin
                pend_q <= cfg_val;
            end
        end

        // copy seen by the comparators, moves only at a period start
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q <= '0;
            end else if (load) begin
                act_q <= pend_q;
            end
        end

        assign lvl_act[k*WW +: WW] = act_q;
    end
endmodule

// File: rtl/gs_section_ctr.sv
module gs_section_ctr
    import gs_pkg::*;
#(
    parameter int LONG_SECT  = 24,
    parameter int SHORT_SECT = 13,
    parameter int IDX_W      = $clog2(LONG_SECT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic             mode_short_in,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] last_idx,
    output logic             short_act,
    output logic             running
);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(LONG_SECT - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_SECT - 1);
    localparam logic [IDX_W-1:0] PRE_LONG   = IDX_W'(LONG_SECT - 2);
    localparam logic [IDX_W-1:0] PRE_SHORT  = IDX_W'(SHORT_SECT - 2);

    sect_state_t      state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic             short_q;
    logic [IDX_W-1:0] pre_last;

    assign last_idx = short_q ? LAST_SHORT : LAST_LONG;
    assign pre_last = short_q ? PRE_SHORT  : PRE_LONG;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_COUNT;
            end
            S_COUNT: begin
                if (start) begin
                    state_d = S_COUNT;
                end else if (tick && (cnt_q == pre_last)) begin
                    state_d = S_SAT;
                end
            end
            S_SAT: begin
                if (start) state_d = S_COUNT;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // section index and captured mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            short_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= '0;
            short_q <= mode_short_in;
        end else if (tick && (state_q == S_COUNT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idx       = cnt_q;
    assign short_act = short_q;
    assign running   = (state_q != S_IDLE);
endmodule

// File: rtl/gs_pixel_map.sv
module gs_pixel_map
    import gs_pkg::*;
#(
    parameter int NUM_WORDS  = 8,
    parameter int LONG_SECT  = 24,
    parameter int SHORT_SECT = 13,
    parameter int IDX_W      = $clog2(LONG_SECT),
    parameter int NLVL       = NUM_LVL,
    parameter int WW         = PWM_W
) (
    input  logic [4*NUM_WORDS-1:0] pix,
    input  logic [NLVL*WW-1:0]     lvl_act,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   short_act,
    input  logic                   running,
    output logic [2*NUM_WORDS-1:0] seg_on
);
    localparam int NSEG = 2 * NUM_WORDS;
    localparam logic [WW-1:0] LIM_LONG  = WW'(LONG_SECT - 1);
    localparam logic [WW-1:0] LIM_SHORT = WW'(SHORT_SECT - 1);

    logic [WW-1:0]      lim;
    logic [NLVL*WW-1:0] eff_flat;

    assign lim = short_act ? LIM_SHORT : LIM_LONG;

    for (genvar k = 0; k < NLVL; k++) begin : g_clamp
        logic [WW-1:0] raw;
        assign raw = lvl_act[k*WW +: WW];
        assign eff_flat[k*WW +: WW] = (raw > lim) ? lim : raw;
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam int BASE = 4 * (s / 2) + (((s % 2) == 0) ? 2 : 0);
        logic [1:0] code;
        logic [1:0] lvl;
        assign code = pix[BASE +: 2];
        // code 11 -> level index 0 ... code 00 -> level index 3
        assign lvl  = ~code;
        assign seg_on[s] = running && (idx < eff_flat[lvl*WW +: WW]);
    end
endmodule

// File: rtl/gs_pwm_seg.sv
module gs_pwm_seg
    import gs_pkg::*;
#(
    parameter int NUM_WORDS  = 8,
    parameter int LONG_SECT  = 24,
    parameter int SHORT_SECT = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   period_start,
    input  logic                   sect_tick,
    input  logic                   mode_short,
    input  logic                   cfg_valid,
    input  logic [CFG_W-1:0]       cfg_word,
    input  logic [4*NUM_WORDS-1:0] pix_data,
    output logic [2*NUM_WORDS-1:0] seg_on
);
    localparam int NSEG     = 2 * NUM_WORDS;
    localparam int PIX_W    = 4 * NUM_WORDS;
    localparam int IDX_W    = $clog2(LONG_SECT);
    localparam int LVL_BITS = NUM_LVL * PWM_W;

    logic [PIX_W-1:0]    pix_act;
    logic [LVL_BITS-1:0] lvl_act;
    logic [IDX_W-1:0]    sect_idx;
    logic [IDX_W-1:0]    last_idx;
    logic                short_act;
    logic                running;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_act <= '0;
        end else if (period_start) begin
            pix_act <= pix_data;
        end
    end

    gs_level_bank #(
        .NLVL (NUM_LVL),
        .WW   (PWM_W),
        .CW   (CFG_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_word  (cfg_word),
        .load      (period_start),
        .lvl_act   (lvl_act)
    );

    gs_section_ctr #(
        .LONG_SECT  (LONG_SECT),
        .SHORT_SECT (SHORT_SECT),
        .IDX_W      (IDX_W)
    ) u_ctr (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (period_start),
        .tick          (sect_tick),
        .mode_short_in (mode_short),
        .idx           (sect_idx),
        .last_idx      (last_idx),
        .short_act     (short_act),
        .running       (running)
    );

    gs_pixel_map #(
        .NUM_WORDS  (NUM_WORDS),
        .LONG_SECT  (LONG_SECT),
        .SHORT_SECT (SHORT_SECT),
        .IDX_W      (IDX_W),
        .NLVL       (NUM_LVL),
        .WW         (PWM_W)
    ) u_map (
        .pix       (pix_act),
        .lvl_act   (lvl_act),
        .idx       (sect_idx),
        .short_act (short_act),
        .running   (running),
        .seg_on    (seg_on)
    );
endmodule

// File: rtl/gs_pwm_seg_chk.sv
module gs_pwm_seg_chk #(
    parameter int NSEG     = 16,
    parameter int IDX_W    = 5,
    parameter int LVL_BITS = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                period_start,
    input logic                sect_tick,
    input logic [NSEG-1:0]     seg_on,
    input logic [IDX_W-1:0]    sect_idx,
    input logic [IDX_W-1:0]    last_idx,
    input logic                running,
    input logic [LVL_BITS-1:0] lvl_act
);
    localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (period_start) begin
            seen_q <= 1'b1;
        end
    end

    a_r1_dark_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (seg_on == '0));

    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> (sect_idx == '0));

    a_r7_tick_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_tick && !period_start && running && (sect_idx != last_idx))
        |=> (sect_idx == $past(sect_idx) + ONE));

    a_r7_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_start && running && (sect_idx == last_idx))
        |=> (sect_idx == $past(sect_idx)));

    // R5 and R6: the clamp keeps every segment dark in the last section
    a_r6_last_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (sect_idx == last_idx)) |-> (seg_on == '0));

    a_r8_levels_held: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(lvl_act));

    a_r4_no_late_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> ((seg_on & ~$past(seg_on)) == '0));
endmodule

bind gs_pwm_seg gs_pwm_seg_chk #(
    .NSEG     (NSEG),
    .IDX_W    (IDX_W),
    .LVL_BITS (LVL_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .sect_tick    (sect_tick),
    .seg_on       (seg_on),
    .sect_idx     (sect_idx),
    .last_idx     (last_idx),
    .running      (running),
    .lvl_act      (lvl_act)
);

// File: tb/sim_gs_pwm_seg.sv
module sim_gs_pwm_seg;
    localparam int NW   = 8;
    localparam int NSEG = 2 * NW;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            period_start;
    logic            sect_tick;
    logic            mode_short;
    logic            cfg_valid;
    logic [14:0]     cfg_word;
    logic [4*NW-1:0] pix_data;
    logic [NSEG-1:0] seg_on;

    always #4 clk = ~clk;

    gs_pwm_seg u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .sect_tick    (sect_tick),
        .mode_short   (mode_short),
        .cfg_valid    (cfg_valid),
        .cfg_word     (cfg_word),
        .pix_data     (pix_data),
        .seg_on       (seg_on)
    );

    // bench model, built from the requirements
    int              pend_m [4];
    int              act_m  [4];
    bit              short_m;
    bit              started_m;
    int              cnt_m;
    logic [4*NW-1:0] pix_m;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    function automatic int lastv(bit sh);
        return sh ? 12 : 23;
    endfunction

    function automatic int clampv(int v, bit sh);
        return (v > lastv(sh)) ? lastv(sh) : v;
    endfunction

    function automatic logic [NSEG-1:0] exp_seg();
        logic [NSEG-1:0] r;
        for (int s = 0; s < NSEG; s++) begin
            logic [1:0] code;
            code = pix_m[4*(s/2) + (((s % 2) == 0) ? 2 : 0) +: 2];
            r[s] = started_m && (cnt_m < clampv(act_m[3 - int'(code)], short_m));
        end
        return r;
    endfunction

    function automatic logic [14:0] mk(int sel, int val);
        return {3'b100, 3'(sel), 5'(val), 4'b0110};
    endfunction

    task automatic check_vec(string req, logic [NSEG-1:0] act, logic [NSEG-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: seg_on=%h expected %h", req, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, update model at posedge, compare at next negedge
    task automatic cyc(bit st, bit tk, bit cv, logic [14:0] cw);
        period_start = st;
        sect_tick    = tk;
        cfg_valid    = cv;
        cfg_word     = cw;
        @(posedge clk);
        if (st) begin
            for (int k = 0; k < 4; k++) act_m[k] = pend_m[k];
            short_m   = mode_short;
            pix_m     = pix_data;
            cnt_m     = 0;
            started_m = 1'b1;
        end else if (tk && started_m && (cnt_m < lastv(short_m))) begin
            cnt_m++;
        end
        if (cv && (cw[14:12] == 3'b100) && (cw[11:9] >= 3'd1) && (cw[11:9] <= 3'd4))
            pend_m[int'(cw[11:9]) - 1] = int'(cw[8:4]);
        @(negedge clk);
        check_vec(tag, seg_on, exp_seg());
    endtask

    task automatic program_levels(int a, int b, int c, int d);
        cyc(0, 0, 1, mk(1, a));
        cyc(0, 0, 1, mk(2, b));
        cyc(0, 0, 1, mk(3, c));
        cyc(0, 0, 1, mk(4, d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run did not complete, got 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int c0, c1, c2, c3;
        for (int k = 0; k < 4; k++) begin
            pend_m[k] = 0;
            act_m[k]  = 0;
        end
        short_m = 0; started_m = 0; cnt_m = 0; pix_m = '0;
        rst_n = 1'b0; period_start = 0; sect_tick = 0; mode_short = 0;
        cfg_valid = 0; cfg_word = '0; pix_data = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_vec("R1", seg_on, '0);
        rst_n = 1'b1;
        pix_data = '1;
        tag = "R1";
        for (int i = 0; i < 6; i++) cyc(0, 1, 0, '0);
        cyc(1, 0, 0, '0);
        check_vec("R1", seg_on, '0);
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, '0);

        // R4/R5: pulse lengths in the long mode
        tag = "R4";
        program_levels(5, 10, 23, 31);
        pix_data = {4{8'h4E}};   // seg0 L1, seg1 L2, seg2 L3, seg3 L4
        mode_short = 0;
        c0 = 0; c1 = 0; c2 = 0; c3 = 0;
        cyc(1, 0, 0, '0);
        for (int i = 0; i < 27; i++) begin
            c0 += int'(seg_on[0]); c1 += int'(seg_on[1]);
            c2 += int'(seg_on[2]); c3 += int'(seg_on[3]);
            cyc(0, 1, 0, '0);
        end
        check_int("R4 level1 width 5", c0, 5);
        check_int("R4 level2 width 10", c1, 10);
        check_int("R5 width 23 long", c2, 23);
        check_int("R5 width 31 clamped", c3, 23);

        // R6: short mode
        tag = "R6";
        mode_short = 1;
        c0 = 0; c1 = 0; c2 = 0; c3 = 0;
        cyc(1, 0, 0, '0);
        for (int i = 0; i < 16; i++) begin
            c0 += int'(seg_on[0]); c1 += int'(seg_on[1]);
            c2 += int'(seg_on[2]); c3 += int'(seg_on[3]);
            cyc(0, 1, 0, '0);
        end
        check_int("R6 width 5 short", c0, 5);
        check_int("R6 width 10 short", c1, 10);
        check_int("R6 width 23 clamped", c2, 12);
        check_int("R6 width 31 clamped", c3, 12);
        mode_short = 0;

        // R2: bit layout and code order
        tag = "R2";
        program_levels(2, 4, 6, 8);
        pix_data = {8{4'b0111}};
        cyc(1, 0, 0, '0);
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, '0);
        check_vec("R2 codes 01/11 at section 3", seg_on, 16'h5555);
        pix_data = {8{4'b1000}};
        cyc(1, 0, 0, '0);
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, '0);
        check_vec("R2 codes 10/00 at section 5", seg_on, 16'hAAAA);

        // R3: malformed configuration words are ignored
        tag = "R3";
        cyc(0, 0, 1, {3'b101, 3'd1, 5'd31, 4'h0});
        cyc(0, 0, 1, {3'b100, 3'd0, 5'd31, 4'h0});
        cyc(0, 0, 1, {3'b100, 3'd5, 5'd31, 4'hF});
        cyc(0, 0, 1, {3'b000, 3'd1, 5'd31, 4'h0});
        cyc(0, 0, 1, {3'b100, 3'd7, 5'd31, 4'h0});
        pix_data = '1;   // all level 1, width 2
        cyc(1, 0, 0, '0);
        check_vec("R3 section 0", seg_on, '1);
        cyc(0, 1, 0, '0);
        cyc(0, 1, 0, '0);
        check_vec("R3 level1 still 2", seg_on, '0);

        // R8: changes mid-period wait for the next start
        tag = "R8";
        cyc(1, 0, 0, '0);
        cyc(0, 0, 1, mk(1, 20));
        pix_data = '0;
        mode_short = 1;
        cyc(0, 1, 0, '0);
        cyc(0, 1, 0, '0);
        check_vec("R8 old width kept", seg_on, '0);
        cyc(1, 0, 1, mk(4, 1));   // write alongside start: deferred
        check_vec("R8 new pixels/level4=8", seg_on, '1);
        for (int i = 0; i < 2; i++) cyc(0, 1, 0, '0);
        check_vec("R8 deferred write not yet", seg_on, '1);
        cyc(1, 0, 0, '0);
        cyc(0, 1, 0, '0);
        check_vec("R8 deferred write applied", seg_on, '0);
        mode_short = 0;

        // R7: start beats tick; saturation does not wrap
        tag = "R7";
        program_levels(1, 4, 6, 31);
        pix_data = '1;
        cyc(1, 1, 0, '0);
        check_vec("R7 start wins over tick", seg_on, '1);
        cyc(0, 1, 0, '0);
        check_vec("R7 step to section 1", seg_on, '0);
        pix_data = '0;
        cyc(1, 0, 0, '0);
        for (int i = 0; i < 40; i++) cyc(0, 1, 0, '0);
        check_vec("R7 held at last section", seg_on, '0);

        // random phase against the model
        tag = "R4";
        void'($urandom(32'd4021));
        for (int i = 0; i < 4000; i++) begin
            int sel;
            logic [2:0] id;
            if (($urandom % 50) == 0) pix_data = 32'($urandom);
            if (($urandom % 200) == 0) mode_short = ~mode_short;
            sel = int'($urandom % 8);
            id  = (($urandom % 5) == 0) ? 3'($urandom) : 3'b100;
            cyc((($urandom % 37) == 0), (($urandom % 3) != 0), (($urandom % 9) == 0),
                {id, 3'(sel), 5'($urandom), 4'($urandom)});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule